// File: doc/BRIEF.md
# Segment buffer invalidate-all engine

This block holds a small segment lookaside buffer and a memory-mapped command register that removes its translations. Each entry keeps a valid flag, a partition tag, a process tag, a class bit and a payload. Software writes a full 64-bit command word. The engine then steps through every entry, one per clock, and clears the valid flag of each entry that the command selects. The scope of a command is all entries, the entries whose partition tag matches, or the entries whose partition and process tags both match. The match values come from a separate selector register, which must be written before the command. A hint in the command can spare the class-0 entries among the selected ones.

Only one command can be in flight. Software polls the command register: a read reports a constant capacity bit and a busy flag. A command written while a walk is still running is discarded. The running walk carries on unchanged, and a saturating counter records the discard. A sticky flag reports a command that carried an undefined hint or nonzero reserved bits. A fill port and a probe port give direct access to the entries. Lookup is handled elsewhere.

Top module: `segbuf_inval`

## Requirements
- R1: A command is accepted only when `reg_wr` is high, `reg_addr` equals 0x090 and all eight `reg_be` bits are set. A partial write, or a write to any other address, starts nothing.
- R2: In the command word, bits [1:0] hold the scope code and bits [4:2] hold the hint. Bits [63:5] are reserved.
- R3: Scope 00 selects every entry. Scope 01 selects entries whose partition tag equals the selector's partition value. Scope 10 selects entries where both tags equal the selector's values. Scope 11 selects nothing, but the walk still runs to completion.
- R4: The selector register is at 0x098 and is written with all byte enables set. Its partition value is in bits [LPID_W-1:0] and its process value is in bits [32+PID_W-1:32]. The engine captures the selector when it accepts a command, so selector writes made during a walk do not affect that walk.
- R5: Hint 000 clears every selected entry. Hint 001 clears only the selected entries whose class bit is 1.
- R6: Any hint other than 000 or 001 behaves as 000. Such a hint, or any nonzero reserved bit in an accepted command, sets `hint_err`. `hint_err` stays set until reset.
- R7: The walk handles entry i, entry 0 included, at the (i+1)th rising edge after the accepting edge. It handles one entry per cycle in ascending order. Valid flags are cleared only during a walk.
- R8: A read with `reg_rd` high returns data on `reg_rdata` after the next edge. For address 0x090, bit 32 is 1, bit 0 is the busy flag and all other bits are 0. Any other address returns 0.
- R9: The busy flag rises at the accepting edge and stays high for exactly NUM_ENTRIES cycles.
- R10: A command accepted by address and byte enables while busy is dropped. The running walk is unchanged, and `drop_count` increments, saturating at all ones.
- R11: A fill sets the valid flag and loads the tags, class and payload of the addressed entry when the engine is idle. A fill is ignored while busy. The probe port returns the stored fields of `probe_idx`.
- R12: After reset, all valid flags, `hint_err` and `drop_count` are 0 and the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_be | input | 8 | Byte enables of the write |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, registered |
| fill_en | input | 1 | Fill strobe |
| fill_idx | input | IDX_W | Entry to fill |
| fill_lpid | input | LPID_W | Partition tag to store |
| fill_pid | input | PID_W | Process tag to store |
| fill_class | input | 1 | Class bit to store |
| fill_payload | input | PAYLOAD_W | Payload to store |
| probe_idx | input | IDX_W | Entry to observe |
| probe_lpid | output | LPID_W | Stored partition tag |
| probe_pid | output | PID_W | Stored process tag |
| probe_class | output | 1 | Stored class bit |
| probe_payload | output | PAYLOAD_W | Stored payload |
| entry_valid | output | NUM_ENTRIES | Valid flag of each entry |
| hint_err | output | 1 | Sticky bad-command flag |
| drop_count | output | DROP_W | Saturating count of dropped commands |

## Verification
The assertions check properties that hold on every cycle:
- the busy window lasts exactly NUM_ENTRIES cycles;
- at most one valid flag clears per cycle, and only while busy;
- no flag rises during a walk;
- a dropped command bumps the counter;
- the error flag never falls;
- the status word's layout follows the busy flag.

Only the bench scenarios can show which entries a given scope, hint and tag pattern actually clears, and in which cycle. They also show that a selector rewrite or a dropped command during a walk leaves its result unchanged, and that partial or misaddressed writes start nothing.

// File: rtl/segbuf_inval_pkg.sv
package segbuf_inval_pkg;

  typedef enum logic [1:0] {
    SCOPE_ALL  = 2'b00,
    SCOPE_PART = 2'b01,
    SCOPE_BOTH = 2'b10,
    SCOPE_NONE = 2'b11
  } scope_e;

  localparam logic [2:0] HINT_DROP_ALL = 3'b000;
  localparam logic [2:0] HINT_KEEP_C0  = 3'b001;

  localparam int unsigned CMD_HINT_LSB = 2;
  localparam int unsigned CMD_RESV_LSB = 5;
  localparam int unsigned SEL_PID_LSB  = 32;
  localparam int unsigned STAT_CAP_BIT = 32;

endpackage

// File: rtl/segbuf_rst_sync.sv
module segbuf_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/segbuf_regs.sv
module segbuf_regs
  import segbuf_inval_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned LPID_W  = 12,
  parameter int unsigned PID_W   = 20,
  parameter logic [ADDR_W-1:0] CMD_OFS = 12'h090,
  parameter logic [ADDR_W-1:0] SEL_OFS = 12'h098
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_be,
  input  logic [63:0]       reg_wdata,
  input  logic              busy,
  output logic              cmd_fire,
  output scope_e            cmd_scope,
  output logic [2:0]        cmd_hint,
  output logic              cmd_resv_bad,
  output logic [LPID_W-1:0] sel_lpid,
  output logic [PID_W-1:0]  sel_pid,
  output logic [63:0]       reg_rdata
);

  logic              full_wr;
  logic              sel_fire;
  logic [LPID_W-1:0] sel_lpid_q, sel_lpid_d;
  logic [PID_W-1:0]  sel_pid_q, sel_pid_d;
  logic [63:0]       rdata_q, rdata_d;
  logic [63:0]       status_word;

  // full 64-bit writes only
  assign full_wr  = reg_wr && (&reg_be);
  assign cmd_fire = full_wr && (reg_addr == CMD_OFS);
  assign sel_fire = full_wr && (reg_addr == SEL_OFS);

  assign cmd_scope    = scope_e'(reg_wdata[1:0]);
  assign cmd_hint     = reg_wdata[CMD_HINT_LSB +: 3];
  assign cmd_resv_bad = |reg_wdata[63:CMD_RESV_LSB];

  always_comb begin
    sel_lpid_d = sel_lpid_q;
    sel_pid_d  = sel_pid_q;
    if (sel_fire) begin
      sel_lpid_d = reg_wdata[LPID_W-1:0];
      sel_pid_d  = reg_wdata[SEL_PID_LSB +: PID_W];
    end
  end

  always_comb begin
    status_word               = '0;
    status_word[STAT_CAP_BIT] = 1'b1;
    status_word[0]            = busy;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (reg_rd) begin
      rdata_d = (reg_addr == CMD_OFS) ? status_word : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_lpid_q <= '0;
      sel_pid_q  <= '0;
      rdata_q    <= '0;
    end else begin
      sel_lpid_q <= sel_lpid_d;
      sel_pid_q  <= sel_pid_d;
      rdata_q    <= rdata_d;
    end
  end

  assign sel_lpid  = sel_lpid_q;
  assign sel_pid   = sel_pid_q;
  assign reg_rdata = rdata_q;

endmodule

// File: rtl/segbuf_walker.sv
module segbuf_walker
  import segbuf_inval_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned LPID_W      = 12,
  parameter int unsigned PID_W       = 20,
  parameter int unsigned DROP_W      = 4,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fire,
  input  scope_e            cmd_scope,
  input  logic [2:0]        cmd_hint,
  input  logic              cmd_resv_bad,
  input  logic [LPID_W-1:0] sel_lpid,
  input  logic [PID_W-1:0]  sel_pid,
  output logic              busy,
  output logic [IDX_W-1:0]  walk_idx,
  output scope_e            crit_scope,
  output logic              crit_keep_c0,
  output logic [LPID_W-1:0] crit_lpid,
  output logic [PID_W-1:0]  crit_pid,
  output logic              hint_err,
  output logic [DROP_W-1:0] drop_count
);

  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_ENTRIES - 1);
  localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};

  logic              busy_q, busy_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  scope_e            scope_q, scope_d;
  logic              keep_q, keep_d;
  logic [LPID_W-1:0] lpid_q, lpid_d;
  logic [PID_W-1:0]  pid_q, pid_d;
  logic              err_q, err_d;
  logic [DROP_W-1:0] drop_q, drop_d;
  logic              hint_known;

  assign hint_known = (cmd_hint == HINT_DROP_ALL) || (cmd_hint == HINT_KEEP_C0);

  always_comb begin
    busy_d  = busy_q;
    idx_d   = idx_q;
    scope_d = scope_q;
    keep_d  = keep_q;
    lpid_d  = lpid_q;
    pid_d   = pid_q;
    err_d   = err_q;
    drop_d  = drop_q;
    if (busy_q) begin
      if (idx_q == LAST_IDX) begin
        busy_d = 1'b0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
      // single outstanding command: newcomer is discarded
      if (cmd_fire && (drop_q != DROP_MAX)) begin
        drop_d = drop_q + 1'b1;
      end
    end else if (cmd_fire) begin
      busy_d  = 1'b1;
      idx_d   = '0;
      scope_d = cmd_scope;
      keep_d  = (cmd_hint == HINT_KEEP_C0);
      lpid_d  = sel_lpid;
      pid_d   = sel_pid;
      if (!hint_known || cmd_resv_bad) begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      scope_q <= SCOPE_NONE;
      keep_q  <= 1'b0;
      lpid_q  <= '0;
      pid_q   <= '0;
      err_q   <= 1'b0;
      drop_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      idx_q   <= idx_d;
      scope_q <= scope_d;
      keep_q  <= keep_d;
      lpid_q  <= lpid_d;
      pid_q   <= pid_d;
      err_q   <= err_d;
      drop_q  <= drop_d;
    end
  end

  assign busy         = busy_q;
  assign walk_idx     = idx_q;
  assign crit_scope   = scope_q;
  assign crit_keep_c0 = keep_q;
  assign crit_lpid    = lpid_q;
  assign crit_pid     = pid_q;
  assign hint_err     = err_q;
  assign drop_count   = drop_q;

endmodule

// File: rtl/segbuf_store.sv
module segbuf_store
  import segbuf_inval_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned LPID_W      = 12,
  parameter int unsigned PID_W       = 20,
  parameter int unsigned PAYLOAD_W   = 32,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fill_en,
  input  logic [IDX_W-1:0]     fill_idx,
  input  logic [LPID_W-1:0]    fill_lpid,
  input  logic [PID_W-1:0]     fill_pid,
  input  logic                 fill_class,
  input  logic [PAYLOAD_W-1:0] fill_payload,
  input  logic                 walk_on,
  input  logic [IDX_W-1:0]     walk_idx,
  input  scope_e               crit_scope,
  input  logic                 crit_keep_c0,
  input  logic [LPID_W-1:0]    crit_lpid,
  input  logic [PID_W-1:0]     crit_pid,
  input  logic [IDX_W-1:0]     probe_idx,
  output logic [LPID_W-1:0]    probe_lpid,
  output logic [PID_W-1:0]     probe_pid,
  output logic                 probe_class,
  output logic [PAYLOAD_W-1:0] probe_payload,
  output logic [NUM_ENTRIES-1:0] entry_valid
);

  logic [LPID_W-1:0]    lpid_arr [NUM_ENTRIES];
  logic [PID_W-1:0]     pid_arr  [NUM_ENTRIES];
  logic                 cls_arr  [NUM_ENTRIES];
  logic [PAYLOAD_W-1:0] pay_arr  [NUM_ENTRIES];

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    logic                 valid_q, valid_d;
    logic [LPID_W-1:0]    lpid_q;
    logic [PID_W-1:0]     pid_q;
    logic                 cls_q;
    logic [PAYLOAD_W-1:0] pay_q;
    logic                 scope_hit;
    logic                 kill;
    logic                 load;

    always_comb begin
      case (crit_scope)
        SCOPE_ALL:  scope_hit = 1'b1;
        SCOPE_PART: scope_hit = (lpid_q == crit_lpid);
        SCOPE_BOTH: scope_hit = (lpid_q == crit_lpid) && (pid_q == crit_pid);
        default:    scope_hit = 1'b0;
      endcase
      kill = walk_on && (walk_idx == IDX_W'(e)) && scope_hit
             && !(crit_keep_c0 && !cls_q);
      load = fill_en && !walk_on && (fill_idx == IDX_W'(e));
      valid_d = valid_q;
      if (load) begin
        valid_d = 1'b1;
      end else if (kill) begin
        valid_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
      end else begin
        valid_q <= valid_d;
      end
    end

    // field storage carries no reset; only the valid flag qualifies it
    always_ff @(posedge clk) begin
      if (load) begin
        lpid_q <= fill_lpid;
        pid_q  <= fill_pid;
        cls_q  <= fill_class;
        pay_q  <= fill_payload;
      end
    end

    assign entry_valid[e] = valid_q;
    assign lpid_arr[e]    = lpid_q;
    assign pid_arr[e]     = pid_q;
    assign cls_arr[e]     = cls_q;
    assign pay_arr[e]     = pay_q;
  end

  assign probe_lpid    = lpid_arr[probe_idx];
  assign probe_pid     = pid_arr[probe_idx];
  assign probe_class   = cls_arr[probe_idx];
  assign probe_payload = pay_arr[probe_idx];

endmodule

// File: rtl/segbuf_inval.sv
module segbuf_inval
  import segbuf_inval_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned LPID_W      = 12,
  parameter int unsigned PID_W       = 20,
  parameter int unsigned PAYLOAD_W   = 32,
  parameter int unsigned DROP_W      = 4,
  parameter int unsigned ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] CMD_OFS = 12'h090,
  parameter logic [ADDR_W-1:0] SEL_OFS = 12'h098,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [7:0]             reg_be,
  input  logic [63:0]            reg_wdata,
  output logic [63:0]            reg_rdata,
  input  logic                   fill_en,
  input  logic [IDX_W-1:0]       fill_idx,
  input  logic [LPID_W-1:0]      fill_lpid,
  input  logic [PID_W-1:0]       fill_pid,
  input  logic                   fill_class,
  input  logic [PAYLOAD_W-1:0]   fill_payload,
  input  logic [IDX_W-1:0]       probe_idx,
  output logic [LPID_W-1:0]      probe_lpid,
  output logic [PID_W-1:0]       probe_pid,
  output logic                   probe_class,
  output logic [PAYLOAD_W-1:0]   probe_payload,
  output logic [NUM_ENTRIES-1:0] entry_valid,
  output logic                   hint_err,
  output logic [DROP_W-1:0]      drop_count
);

  logic              rst_sync_n;
  logic              cmd_fire;
  scope_e            cmd_scope;
  logic [2:0]        cmd_hint;
  logic              cmd_resv_bad;
  logic [LPID_W-1:0] sel_lpid;
  logic [PID_W-1:0]  sel_pid;
  logic              busy;
  logic [IDX_W-1:0]  walk_idx;
  scope_e            crit_scope;
  logic              crit_keep_c0;
  logic [LPID_W-1:0] crit_lpid;
  logic [PID_W-1:0]  crit_pid;

  segbuf_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  segbuf_regs #(
    .ADDR_W  (ADDR_W),
    .LPID_W  (LPID_W),
    .PID_W   (PID_W),
    .CMD_OFS (CMD_OFS),
    .SEL_OFS (SEL_OFS)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_be       (reg_be),
    .reg_wdata    (reg_wdata),
    .busy         (busy),
    .cmd_fire     (cmd_fire),
    .cmd_scope    (cmd_scope),
    .cmd_hint     (cmd_hint),
    .cmd_resv_bad (cmd_resv_bad),
    .sel_lpid     (sel_lpid),
    .sel_pid      (sel_pid),
    .reg_rdata    (reg_rdata)
  );

  segbuf_walker #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .LPID_W      (LPID_W),
    .PID_W       (PID_W),
    .DROP_W      (DROP_W)
  ) u_walk (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .cmd_fire     (cmd_fire),
    .cmd_scope    (cmd_scope),
    .cmd_hint     (cmd_hint),
    .cmd_resv_bad (cmd_resv_bad),
    .sel_lpid     (sel_lpid),
    .sel_pid      (sel_pid),
    .busy         (busy),
    .walk_idx     (walk_idx),
    .crit_scope   (crit_scope),
    .crit_keep_c0 (crit_keep_c0),
    .crit_lpid    (crit_lpid),
    .crit_pid     (crit_pid),
    .hint_err     (hint_err),
    .drop_count   (drop_count)
  );

  segbuf_store #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .LPID_W      (LPID_W),
    .PID_W       (PID_W),
    .PAYLOAD_W   (PAYLOAD_W)
  ) u_store (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .fill_en       (fill_en),
    .fill_idx      (fill_idx),
    .fill_lpid     (fill_lpid),
    .fill_pid      (fill_pid),
    .fill_class    (fill_class),
    .fill_payload  (fill_payload),
    .walk_on       (busy),
    .walk_idx      (walk_idx),
    .crit_scope    (crit_scope),
    .crit_keep_c0  (crit_keep_c0),
    .crit_lpid     (crit_lpid),
    .crit_pid      (crit_pid),
    .probe_idx     (probe_idx),
    .probe_lpid    (probe_lpid),
    .probe_pid     (probe_pid),
    .probe_class   (probe_class),
    .probe_payload (probe_payload),
    .entry_valid   (entry_valid)
  );

endmodule

// File: rtl/segbuf_inval_chk.sv
module segbuf_inval_chk #(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned DROP_W      = 4,
  parameter int unsigned ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] CMD_OFS = 12'h090
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_fire,
  input logic                   busy,
  input logic [NUM_ENTRIES-1:0] entry_valid,
  input logic                   hint_err,
  input logic [DROP_W-1:0]      drop_count,
  input logic                   reg_rd,
  input logic [ADDR_W-1:0]      reg_addr,
  input logic [63:0]            reg_rdata
);

  localparam int unsigned LEN_W = $clog2(NUM_ENTRIES) + 1;

  logic [LEN_W-1:0] busy_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_len_q <= '0;
    end else if (busy) begin
      busy_len_q <= busy_len_q + 1'b1;
    end else begin
      busy_len_q <= '0;
    end
  end

  // R9: busy window never exceeds, and always reaches, NUM_ENTRIES cycles
  assert_busy_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_len_q < LEN_W'(NUM_ENTRIES)));

  assert_busy_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len_q == LEN_W'(NUM_ENTRIES)));

  assert_accept_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && !busy) |=> busy);

  assert_drop_counted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && busy) |=>
      ((drop_count == DROP_W'($past(drop_count) + 1'b1)) || (&$past(drop_count))));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hint_err |=> hint_err);

  assert_no_fill_in_walk_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((entry_valid & ~$past(entry_valid)) == '0));

  assert_one_clear_per_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones($past(entry_valid) & ~entry_valid) <= 1);

  assert_clear_only_in_walk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(entry_valid) & ~entry_valid) != '0) |-> $past(busy));

  assert_status_layout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == CMD_OFS)) |=>
      (reg_rdata[32] && (reg_rdata[0] == $past(busy))
       && (reg_rdata[63:33] == '0) && (reg_rdata[31:1] == '0)));

endmodule

bind segbuf_inval segbuf_inval_chk #(
  .NUM_ENTRIES (NUM_ENTRIES),
  .DROP_W      (DROP_W),
  .ADDR_W      (ADDR_W),
  .CMD_OFS     (CMD_OFS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cmd_fire    (cmd_fire),
  .busy        (busy),
  .entry_valid (entry_valid),
  .hint_err    (hint_err),
  .drop_count  (drop_count),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr),
  .reg_rdata   (reg_rdata)
);

// File: tb/segbuf_inval_tb_top.sv
module segbuf_inval_tb_top;

  localparam int NE = 8;
  localparam logic [11:0] A_CMD = 12'h090;
  localparam logic [11:0] A_SEL = 12'h098;
  localparam logic [63:0] STAT_IDLE = 64'h1_0000_0000;

  logic        clk;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [11:0] reg_addr;
  logic [7:0]  reg_be;
  logic [63:0] reg_wdata, reg_rdata;
  logic        fill_en;
  logic [2:0]  fill_idx, probe_idx;
  logic [11:0] fill_lpid, probe_lpid;
  logic [19:0] fill_pid, probe_pid;
  logic        fill_class, probe_class;
  logic [31:0] fill_payload, probe_payload;
  logic [7:0]  entry_valid;
  logic        hint_err;
  logic [3:0]  drop_count;

  int n_checks = 0;
  int n_fail   = 0;
  logic exp_err;
  logic [11:0] t_lpid [NE];
  logic [19:0] t_pid  [NE];
  logic        t_cls  [NE];

  segbuf_inval #(.NUM_ENTRIES(NE)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fill_en(fill_en), .fill_idx(fill_idx),
    .fill_lpid(fill_lpid), .fill_pid(fill_pid), .fill_class(fill_class),
    .fill_payload(fill_payload), .probe_idx(probe_idx),
    .probe_lpid(probe_lpid), .probe_pid(probe_pid),
    .probe_class(probe_class), .probe_payload(probe_payload),
    .entry_valid(entry_valid), .hint_err(hint_err), .drop_count(drop_count)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d, input logic [7:0] be);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic fill(input int i, input logic [11:0] l, input logic [19:0] p,
                      input logic c, input logic [31:0] pay);
    @(negedge clk);
    fill_en = 1'b1; fill_idx = 3'(i); fill_lpid = l; fill_pid = p;
    fill_class = c; fill_payload = pay;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  // issue a command, then watch status and valid flags on every cycle
  task automatic run_cmd(input logic [63:0] cmd, input logic [7:0] init,
                         input logic [7:0] clr, input string tag);
    logic [7:0] m;
    wr(A_CMD, cmd, 8'hFF);
    reg_rd = 1'b1; reg_addr = A_CMD;
    for (int k = 1; k <= NE + 1; k++) begin
      @(negedge clk);
      m = (k >= NE) ? 8'hFF : 8'((1 << k) - 1);
      chk({tag, " R8/R9 status"}, reg_rdata, STAT_IDLE | 64'(k <= NE));
      chk({tag, " R3/R5/R7 walk"}, 64'(entry_valid), 64'(init & ~(clr & m)));
    end
    reg_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 reset valid", 64'(entry_valid), 64'h0);
    chk("R12 reset err", 64'(hint_err), 64'h0);
    chk("R12 reset drops", 64'(drop_count), 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [7:0]  clr;
    logic        hit;
    int          s;
    reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_be = '0; reg_wdata = '0;
    fill_en = 0; fill_idx = '0; fill_lpid = '0; fill_pid = '0;
    fill_class = 0; fill_payload = '0; probe_idx = '0;
    rst_n = 1'b0;
    do_reset();
    rd(A_CMD, d);
    chk("R8 idle status", d, STAT_IDLE);
    rd(A_SEL, d);
    chk("R8 other address", d, 64'h0);

    // R1: partial or misaddressed writes do nothing
    for (int i = 0; i < NE; i++) fill(i, 12'd5, 20'd9, 1'b0, 32'(i));
    wr(A_CMD, 64'h0, 8'h0F);
    rd(A_CMD, d);
    chk("R1 partial write", d, STAT_IDLE);
    wr(12'h0A0, 64'h0, 8'hFF);
    rd(A_CMD, d);
    chk("R1 wrong address", d, STAT_IDLE);
    chk("R1 valid kept", 64'(entry_valid), 64'hFF);

    // sweep of every scope and hint: R2 R3 R5 R6 R7 R9 R11
    exp_err = 1'b0;
    wr(A_SEL, (64'd9 << 32) | 64'd5, 8'hFF);
    for (int q = 0; q < 4; q++) begin
      for (int h = 0; h < 8; h++) begin
        s = q * 8 + h;
        clr = '0;
        for (int i = 0; i < NE; i++) begin
          t_lpid[i] = 12'(5 + ((i + s) % 3));
          t_pid[i]  = ((i + s) % 2 == 1) ? 20'd9 : 20'd3;
          t_cls[i]  = 1'((i / 2 + s) % 2);
          fill(i, t_lpid[i], t_pid[i], t_cls[i], 32'(s * 16 + i));
          hit = (q == 0) || (q == 1 && t_lpid[i] == 12'd5)
                || (q == 2 && t_lpid[i] == 12'd5 && t_pid[i] == 20'd9);
          clr[i] = hit && !(h == 1 && !t_cls[i]);
        end
        probe_idx = 3'(s % NE);
        @(negedge clk);
        chk("R11 probe payload", 64'(probe_payload), 64'(s * 16 + s % NE));
        chk("R11 probe tags", {probe_lpid, probe_pid, probe_class},
            {t_lpid[s % NE], t_pid[s % NE], t_cls[s % NE]});
        if (h > 1) exp_err = 1'b1;
        run_cmd(64'((h << 2) | q), 8'hFF, clr, $sformatf("q%0d h%0d", q, h));
        chk("R6 hint err", 64'(hint_err), 64'(exp_err));
      end
    end
    chk("R10 no drops yet", 64'(drop_count), 64'h0);

    // R4/R10/R11: selector rewrite, fill and extra commands during a walk
    for (int i = 0; i < NE; i++) fill(i, 12'd5, 20'd9, 1'b1, 32'(i));
    wr(A_CMD, 64'h1, 8'hFF);
    wr(A_SEL, 64'd6, 8'hFF);
    fill(0, 12'd5, 20'd9, 1'b1, 32'd0);
    wr(A_CMD, 64'h3, 8'hFF);
    wr(A_CMD, 64'h3, 8'hFF);
    repeat (4) @(negedge clk);
    chk("R4/R10/R11 walk result", 64'(entry_valid), 64'h0);
    chk("R10 drop count", 64'(drop_count), 64'd2);
    for (int i = 0; i < NE; i++) fill(i, 12'd5, 20'd9, 1'b1, 32'(i));
    run_cmd(64'h1, 8'hFF, 8'h00, "R4 new selector");

    // R10: continuous writes, then saturation
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_CMD; reg_wdata = 64'h3; reg_be = 8'hFF;
    repeat (10) @(negedge clk);
    reg_wr = 1'b0;
    chk("R10 drops counted", 64'(drop_count), 64'd10);
    reg_wr = 1'b1;
    repeat (20) @(negedge clk);
    reg_wr = 1'b0;
    chk("R10 drops saturate", 64'(drop_count), 64'd15);
    repeat (12) @(negedge clk);

    // R6: reserved bits flag the command after a fresh reset
    do_reset();
    for (int i = 0; i < NE; i++) fill(i, 12'd1, 20'd1, 1'b0, 32'(i));
    run_cmd(64'd1 << 40, 8'hFF, 8'hFF, "R6 reserved");
    chk("R6 reserved err", 64'(hint_err), 64'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule